// File: doc/BRIEF.md
# Multi-Function I/O Configuration Port

This block holds the configuration state of a multi-function I/O device and is programmed over a two-address host register bus. Address 0 is the index port and address 1 is the data port. Configuration access is closed after reset. The host opens it by writing a key byte to the index port, and closes it with a second key byte.

While access is open, the host writes a register number to the index port and then reads or writes that register through the data port. A global select register picks one logical device. Every device register access after that goes to the register bank of the selected device. Each bank holds an I/O base address, two IRQ numbers, a DMA channel, two mode bytes and an activate bit. The settings of all banks drive the block outputs continuously, so the functional units that use them can be wired straight to the ports.

Five logical device numbers are implemented: 0 (floppy), 3 (parallel), 4 (serial 1), 5 (serial 2) and 7 (keyboard). On every per-device output vector they appear as slots 0 to 4, in that order.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, access is closed (`cfg_open_o`=0), every register in every bank is 0x00, `dev_en_o` is 0 and the device select register reads 0x00.
- R2: An index-port write of 0x55 while closed opens access. An index-port write of 0xAA while open closes it. While open, any other index-port write sets the index, and key writes leave the index unchanged.
- R3: While closed, data-port writes and all index-port writes other than 0x55 have no effect, and reads of either port return 0xFF.
- R4: Global register 0x07 selects the logical device number and reads back the value last written.
- R5: Global register 0x20 always reads 0x40, and writes to it have no effect.
- R6: In the selected bank, register 0x60 holds the base address high byte and 0x61 the low byte. Register 0x70 holds the IRQ, 0x72 the second IRQ, 0x74 the DMA channel, and 0xF0 and 0xF1 the mode bytes. Each reads back as written and drives its slot of `dev_base_o`, `dev_irq_o`, `dev_irq2_o`, `dev_dma_o`, `dev_mode0_o` or `dev_mode1_o`. Slot s sits at bits [s*W +: W].
- R7: Bit 0 of register 0x30 is the activate bit of the selected device and drives `dev_en_o[slot]`. A read of 0x30 returns this bit with bits 7:1 zero.
- R8: A device register write changes only the bank of the selected device. All other banks keep their values.
- R9: When the selected device number is not 0, 3, 4, 5 or 7, device registers read 0x00 and writes to them have no effect. Unimplemented register numbers in any bank or in the global area also read 0x00 and ignore writes.
- R10: `fdd_on_lpt_o` is high exactly when register 0xF1 of device 3 holds 0x02.
- R11: A write updates registers and outputs at the clock edge that samples it. Read data appears on `rdata_o` after the edge that samples `rd_en_i` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 1 | 0 = index port, 1 = data port |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Registered read data |
| cfg_open_o | output | 1 | Configuration access open |
| dev_en_o | output | 5 | Activate bit per slot |
| dev_base_o | output | 80 | 16-bit I/O base per slot |
| dev_irq_o | output | 40 | IRQ byte per slot |
| dev_irq2_o | output | 40 | Second IRQ byte per slot |
| dev_dma_o | output | 40 | DMA channel byte per slot |
| dev_mode0_o | output | 40 | Mode byte 0 per slot |
| dev_mode1_o | output | 40 | Mode byte 1 per slot |
| fdd_on_lpt_o | output | 1 | Floppy routed to the parallel device |

## Verification
Every bus access takes one cycle. A write lands on the state outputs at the edge that samples it, and read data is on `rdata_o` one edge after the strobe. The driver changes inputs on the falling edge. It checks the state outputs on the falling edge right after the write edge. For each read it queues the expected byte, and a monitor pops and compares that byte on the falling edge after the edge that captured the strobe. A read and its check are therefore always exactly one edge apart.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int DW      = 8;
  localparam int BASE_W  = 2 * DW;
  localparam int NUM_DEV = 5;
  localparam int SLOT_W  = $clog2(NUM_DEV);

  localparam logic [DW-1:0] KEY_OPEN  = 8'h55;
  localparam logic [DW-1:0] KEY_CLOSE = 8'hAA;
  localparam logic [DW-1:0] LOCKED_RD = 8'hFF;

  localparam logic [DW-1:0] REG_LDN   = 8'h07;
  localparam logic [DW-1:0] REG_ID    = 8'h20;
  localparam logic [DW-1:0] ID_VALUE  = 8'h40;
  localparam logic [DW-1:0] DEV_FIRST = 8'h30;

  localparam logic [DW-1:0] REG_ACT   = 8'h30;
  localparam logic [DW-1:0] REG_BASEH = 8'h60;
  localparam logic [DW-1:0] REG_BASEL = 8'h61;
  localparam logic [DW-1:0] REG_IRQ   = 8'h70;
  localparam logic [DW-1:0] REG_IRQ2  = 8'h72;
  localparam logic [DW-1:0] REG_DMA   = 8'h74;
  localparam logic [DW-1:0] REG_MODE0 = 8'hF0;
  localparam logic [DW-1:0] REG_MODE1 = 8'hF1;

  localparam int              LPT_SLOT   = 1;
  localparam logic [DW-1:0]   FDD_ON_LPT = 8'h02;

  typedef struct packed {
    logic            act;
    logic [DW-1:0]   base_h;
    logic [DW-1:0]   base_l;
    logic [DW-1:0]   irq;
    logic [DW-1:0]   irq2;
    logic [DW-1:0]   dma;
    logic [DW-1:0]   mode0;
    logic [DW-1:0]   mode1;
  } dev_regs_t;

  // logical device number owned by each slot
  function automatic logic [DW-1:0] slot_ldn(input int s);
    case (s)
      0:       return 8'd0;
      1:       return 8'd3;
      2:       return 8'd4;
      3:       return 8'd5;
      default: return 8'd7;
    endcase
  endfunction
endpackage

// File: rtl/sio_cfg_lock.sv
module sio_cfg_lock
  import sio_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          open_o,
  output logic [DW-1:0] idx_o
);
  logic idx_wr;
  assign idx_wr = wr_i && !addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      idx_o  <= '0;
    end else if (idx_wr) begin
      if (!open_o) begin
        if (wdata_i == KEY_OPEN) open_o <= 1'b1;
      end else if (wdata_i == KEY_CLOSE) begin
        open_o <= 1'b0;
      end else begin
        idx_o <= wdata_i;
      end
    end
  end

  assert_key_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_wr && !open_o && wdata_i == KEY_OPEN) |=> open_o);
  assert_key_close_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_wr && open_o && wdata_i == KEY_CLOSE) |=> !open_o);
  assert_closed_idx_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_o |=> $stable(idx_o));
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
  import sio_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output dev_regs_t     regs_o
);
  dev_regs_t r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r <= '0;
    end else if (wr_i) begin
      case (idx_i)
        REG_ACT:   r.act    <= wdata_i[0];
        REG_BASEH: r.base_h <= wdata_i;
        REG_BASEL: r.base_l <= wdata_i;
        REG_IRQ:   r.irq    <= wdata_i;
        REG_IRQ2:  r.irq2   <= wdata_i;
        REG_DMA:   r.dma    <= wdata_i;
        REG_MODE0: r.mode0  <= wdata_i;
        REG_MODE1: r.mode1  <= wdata_i;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (idx_i)
      REG_ACT:   rdata_o = {{(DW-1){1'b0}}, r.act};
      REG_BASEH: rdata_o = r.base_h;
      REG_BASEL: rdata_o = r.base_l;
      REG_IRQ:   rdata_o = r.irq;
      REG_IRQ2:  rdata_o = r.irq2;
      REG_DMA:   rdata_o = r.dma;
      REG_MODE0: rdata_o = r.mode0;
      REG_MODE1: rdata_o = r.mode1;
      default:   rdata_o = '0;
    endcase
  end

  assign regs_o = r;

  assert_bank_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(regs_o));
  assert_act_rd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i == REG_ACT) |-> (rdata_o[DW-1:1] == '0));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic                   addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   cfg_open_o,
  output logic [NUM_DEV-1:0]     dev_en_o,
  output logic [NUM_DEV*BASE_W-1:0] dev_base_o,
  output logic [NUM_DEV*DW-1:0]  dev_irq_o,
  output logic [NUM_DEV*DW-1:0]  dev_irq2_o,
  output logic [NUM_DEV*DW-1:0]  dev_dma_o,
  output logic [NUM_DEV*DW-1:0]  dev_mode0_o,
  output logic [NUM_DEV*DW-1:0]  dev_mode1_o,
  output logic                   fdd_on_lpt_o
);
  logic          open_q;
  logic [DW-1:0] idx_q;
  logic [DW-1:0] ldn_q;
  logic          data_wr;
  logic          dev_area;
  logic [NUM_DEV-1:0] hit;
  logic [DW-1:0] bank_rd [NUM_DEV];
  dev_regs_t     bank_regs [NUM_DEV];
  logic [DW-1:0] dev_rd;
  logic [DW-1:0] data_rd;

  sio_cfg_lock u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .open_o (open_q),
    .idx_o  (idx_q)
  );

  assign data_wr  = wr_en_i && addr_i && open_q;
  assign dev_area = (idx_q >= DEV_FIRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ldn_q <= '0;
    else if (data_wr && idx_q == REG_LDN)       ldn_q <= wdata_i;
  end

  for (genvar s = 0; s < NUM_DEV; s++) begin : g_bank
    assign hit[s] = (ldn_q == slot_ldn(s));

    sio_dev_bank u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (data_wr && dev_area && hit[s]),
      .idx_i  (idx_q),
      .wdata_i(wdata_i),
      .rdata_o(bank_rd[s]),
      .regs_o (bank_regs[s])
    );

    assign dev_en_o[s]                  = bank_regs[s].act;
    assign dev_base_o[s*BASE_W +: BASE_W] = {bank_regs[s].base_h, bank_regs[s].base_l};
    assign dev_irq_o[s*DW +: DW]        = bank_regs[s].irq;
    assign dev_irq2_o[s*DW +: DW]       = bank_regs[s].irq2;
    assign dev_dma_o[s*DW +: DW]        = bank_regs[s].dma;
    assign dev_mode0_o[s*DW +: DW]      = bank_regs[s].mode0;
    assign dev_mode1_o[s*DW +: DW]      = bank_regs[s].mode1;
  end

  // unselected or unimplemented device contributes zero
  always_comb begin
    dev_rd = '0;
    for (int s = 0; s < NUM_DEV; s++) begin
      if (hit[s]) dev_rd = dev_rd | bank_rd[s];
    end
  end

  always_comb begin
    if (dev_area)               data_rd = dev_rd;
    else if (idx_q == REG_LDN)  data_rd = ldn_q;
    else if (idx_q == REG_ID)   data_rd = ID_VALUE;
    else                        data_rd = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (rd_en_i) begin
      if (!open_q)      rdata_o <= LOCKED_RD;
      else if (addr_i)  rdata_o <= data_rd;
      else              rdata_o <= idx_q;
    end
  end

  assign cfg_open_o   = open_q;
  assign fdd_on_lpt_o = (bank_regs[LPT_SLOT].mode1 == FDD_ON_LPT);

  assert_closed_rd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !open_q) |=> (rdata_o == LOCKED_RD));
  assert_closed_nowr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_q |=> ($stable(dev_base_o) && $stable(dev_en_o) && $stable(dev_mode1_o)));
  assert_id_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && open_q && addr_i && idx_q == REG_ID) |=> (rdata_o == ID_VALUE));
  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  assert_one_slot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  import sio_cfg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic cfg_open, fdd_on_lpt;
  logic [NUM_DEV-1:0] dev_en;
  logic [NUM_DEV*16-1:0] dev_base;
  logic [NUM_DEV*8-1:0] dev_irq, dev_irq2, dev_dma, dev_mode0, dev_mode1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic rd_pend = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  sio_cfg_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cfg_open_o(cfg_open),
    .dev_en_o(dev_en), .dev_base_o(dev_base), .dev_irq_o(dev_irq),
    .dev_irq2_o(dev_irq2), .dev_dma_o(dev_dma), .dev_mode0_o(dev_mode0),
    .dev_mode1_o(dev_mode1), .fdd_on_lpt_o(fdd_on_lpt)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data one edge after the strobe
  always @(posedge clk) rd_pend <= rd_en;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11 unexpected read actual=%0h expected=none", rdata);
      end else begin
        chk(tag_q.pop_front(), 128'(rdata), 128'(exp_q.pop_front()));
      end
    end
  end

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] i, input logic [7:0] v);
    bus_wr(1'b0, i); bus_wr(1'b1, v);
  endtask

  task automatic rreg(input logic [7:0] i, input logic [7:0] exp, input string tag);
    bus_wr(1'b0, i); bus_rd(1'b1, exp, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg_open", 128'(cfg_open), 128'(0));
    chk("R1 dev_en", 128'(dev_en), 128'(0));
    chk("R1 dev_base", 128'(dev_base), 128'(0));
    chk("R1 fdd_on_lpt", 128'(fdd_on_lpt), 128'(0));
    // R3 closed reads
    bus_rd(1'b1, 8'hFF, "R3 closed data read");
    bus_rd(1'b0, 8'hFF, "R3 closed index read");
    // R2 open key
    bus_wr(1'b0, 8'h55);
    chk("R2 open", 128'(cfg_open), 128'(1));
    rreg(8'h07, 8'h00, "R1 select after reset");
    rreg(8'h20, 8'h40, "R5 id");
    wreg(8'h20, 8'h11);
    bus_rd(1'b1, 8'h40, "R5 id after write");
    // R3 closed write ignored, index kept
    bus_wr(1'b0, 8'h60);
    bus_wr(1'b0, 8'hAA);
    chk("R2 close", 128'(cfg_open), 128'(0));
    bus_wr(1'b1, 8'h12);
    bus_wr(1'b0, 8'h61);
    chk("R3 closed write no base", 128'(dev_base), 128'(0));
    bus_wr(1'b0, 8'h55);
    bus_rd(1'b0, 8'h60, "R2 index kept across keys");
    bus_rd(1'b1, 8'h00, "R3 closed write ignored");
    // parallel device, LDN 3 -> slot 1
    wreg(8'h07, 8'h03);
    wreg(8'h60, 8'h03);
    wreg(8'h61, 8'h78);
    chk("R6 R11 base slot1", 128'(dev_base[16 +: 16]), 128'(16'h0378));
    wreg(8'h70, 8'h07);
    chk("R6 irq slot1", 128'(dev_irq[8 +: 8]), 128'(8'h07));
    wreg(8'hF1, 8'h02);
    chk("R10 fdd on lpt", 128'(fdd_on_lpt), 128'(1));
    wreg(8'h30, 8'hFF);
    chk("R7 enable slot1", 128'(dev_en), 128'(5'b00010));
    rreg(8'h30, 8'h01, "R7 act readback");
    rreg(8'h61, 8'h78, "R6 base low readback");
    rreg(8'h07, 8'h03, "R4 select readback");
    // floppy, LDN 0 -> slot 0
    wreg(8'h07, 8'h00);
    wreg(8'h74, 8'h02);
    wreg(8'hF0, 8'h05);
    wreg(8'h60, 8'h03);
    wreg(8'h61, 8'hF0);
    chk("R6 dma slot0", 128'(dev_dma[0 +: 8]), 128'(8'h02));
    chk("R6 mode0 slot0", 128'(dev_mode0[0 +: 8]), 128'(8'h05));
    chk("R8 other banks", 128'(dev_base), 128'({16'h0, 16'h0, 16'h0, 16'h0378, 16'h03F0}));
    rreg(8'h70, 8'h00, "R8 slot0 irq untouched");
    // keyboard, LDN 7 -> slot 4
    wreg(8'h07, 8'h07);
    wreg(8'h70, 8'h01);
    wreg(8'h72, 8'h0C);
    chk("R6 irq slot4", 128'(dev_irq[32 +: 8]), 128'(8'h01));
    chk("R6 irq2 slot4", 128'(dev_irq2[32 +: 8]), 128'(8'h0C));
    rreg(8'h72, 8'h0C, "R6 irq2 readback");
    // serial 1, LDN 4: unimplemented register
    wreg(8'h07, 8'h04);
    wreg(8'h50, 8'h99);
    bus_rd(1'b1, 8'h00, "R9 unimplemented reg");
    rreg(8'h10, 8'h00, "R9 unimplemented global");
    // unimplemented LDN 2
    wreg(8'h07, 8'h02);
    wreg(8'h60, 8'h55);
    wreg(8'h30, 8'h01);
    bus_rd(1'b1, 8'h00, "R9 unimplemented device read");
    chk("R9 no base change", 128'(dev_base), 128'({16'h0, 16'h0, 16'h0, 16'h0378, 16'h03F0}));
    chk("R9 no enable change", 128'(dev_en), 128'(5'b00010));
    rreg(8'h07, 8'h02, "R4 select unimplemented");
    // mode change on parallel device
    wreg(8'h07, 8'h03);
    wreg(8'hF1, 8'h00);
    chk("R10 fdd off", 128'(fdd_on_lpt), 128'(0));
    rreg(8'hF1, 8'h00, "R6 mode1 readback");
    // close and verify
    bus_wr(1'b0, 8'hAA);
    bus_rd(1'b1, 8'hFF, "R3 closed after use");
    bus_wr(1'b1, 8'h02);
    chk("R3 closed write no mode", 128'(fdd_on_lpt), 128'(0));
    chk("R3 state retained", 128'(dev_irq[8 +: 8]), 128'(8'h07));
    repeat (3) @(negedge clk);
    chk("R11 read queue drained", 128'(exp_q.size()), 128'(0));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule